// File: doc/BRIEF.md
# Floating-Gate Byte Array Emulator

This block is a synthesizable stand-in for a small non-volatile byte store. It keeps the one-way bit behaviour of floating-gate cells: a program operation can only pull bits from one to zero, and only an erase can return bits to one. An erase works on one byte, on one aligned 16-byte row, or on the whole array. A separate single-byte configuration cell sits beside the array. It accepts the same program and byte-erase operations and is never touched by an array-wide erase.

An operation is issued with a one-cycle strobe. The strobe carries an erase flag, two granularity bits, a target select for the configuration cell, a byte address and program data. The operation takes effect at the clock edge that samples the strobe. The combinational read port and the configuration output show the new contents from the next cycle. The active-low reset stands for power-up and fills every cell with all ones. Sequence enforcement, protection and anything analog belong to neighbouring blocks.

Top module: `fgate_array_emu`

## Requirements
- R1: After reset every array byte and the configuration cell read 8'hFF.
- R2: A program to an array byte (opErase=0, cfgSel=0) stores old AND opData in that byte and leaves every other byte and the configuration cell unchanged.
- R3: Repeated programs to one byte accumulate as a bitwise AND; a program never changes a zero bit back to one.
- R4: An erase with modeByte=1 sets only the addressed array byte to 8'hFF, whatever the value of modeRow.
- R5: An erase with modeByte=0 and modeRow=1 sets to 8'hFF the 16 bytes whose address bits [8:4] match opAddr[8:4] and leaves all other bytes unchanged.
- R6: An erase with modeByte=0 and modeRow=0 sets every array byte to 8'hFF and leaves the configuration cell unchanged.
- R7: With cfgSel=1, a program stores cfg AND opData, and an erase with modeByte=1 sets the cell to 8'hFF. The array is not changed in either case.
- R8: With cfgSel=1, an erase with modeByte=0 changes neither the configuration cell nor the array.
- R9: During the cycle in which opStrobe is high, rdData shows the value from before the operation. The new value appears after that clock edge.
- R10: While opStrobe is low, changes on the other operation inputs change no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset; fills all cells with ones |
| opStrobe | input | 1 | Applies the operation described by the other op inputs at this edge |
| opErase | input | 1 | 1 = erase, 0 = program |
| modeByte | input | 1 | Erase granularity: single byte when set (overrides modeRow) |
| modeRow | input | 1 | Erase granularity when modeByte=0: 1 = row, 0 = whole array |
| cfgSel | input | 1 | Targets the configuration cell instead of the array |
| opAddr | input | 9 | Array byte address of the operation |
| opData | input | 8 | Program data (zeros clear bits) |
| rdAddr | input | 9 | Read port address |
| rdData | output | 8 | Array byte at rdAddr (combinational) |
| cfgData | output | 8 | Current configuration cell value |

## Verification
The bench builds the block with its default parameters: a 9-bit address, 8-bit bytes and 16-byte rows. This makes full 512-byte sweeps of the read port cheap after every phase, so the effect of each row or array erase can be checked on every byte. A behavioural byte array in the bench mirrors each strobe and is compared with rdData and cfgData on every cycle. Row erases are issued at addresses inside a row and in the last row, byte erases are issued with modeRow both clear and set, and the configuration cell is hit with every erase mode.

// File: rtl/fgate_pkg.sv
package fgate_pkg;

  // One-hot strobes from the decoder to the storage datapath.
  typedef struct packed {
    logic arrProg;
    logic arrByteErase;
    logic arrRowErase;
    logic arrBulkErase;
    logic cfgProg;
    logic cfgErase;
  } fgate_strobe_t;

endpackage

// File: rtl/fgate_ctrl.sv
module fgate_ctrl
  import fgate_pkg::*;
(
  input  logic          opStrobe,
  input  logic          opErase,
  input  logic          modeByte,
  input  logic          modeRow,
  input  logic          cfgSel,
  output fgate_strobe_t stb
);

  logic doProg;
  logic doErase;

  assign doProg  = opStrobe & ~opErase;
  assign doErase = opStrobe &  opErase;

  always_comb begin
    stb              = '0;
    // Array targets
    stb.arrProg      = doProg  & ~cfgSel;
    stb.arrByteErase = doErase & ~cfgSel &  modeByte;
    stb.arrRowErase  = doErase & ~cfgSel & ~modeByte &  modeRow;
    stb.arrBulkErase = doErase & ~cfgSel & ~modeByte & ~modeRow;
    // Configuration cell: program and single-byte erase only
    stb.cfgProg      = doProg  &  cfgSel;
    stb.cfgErase     = doErase &  cfgSel &  modeByte;
  end

endmodule

// File: rtl/fgate_datapath.sv
module fgate_datapath
  import fgate_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fgate_strobe_t     stb,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] cfgData
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int ROWS  = 1 << (ADDR_W - ROW_W);
  localparam int ROWSZ = 1 << ROW_W;
  localparam logic [DATA_W-1:0] ERASED = '1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] cfgReg;
  logic [ROWS-1:0]   rowHit;
  logic [DATA_W-1:0] tgtOld;

  // Row decode: one select line per row
  generate
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign rowHit[r] = stb.arrRowErase &&
                         (opAddr[ADDR_W-1:ROW_W] == (ADDR_W-ROW_W)'(r));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (stb.arrBulkErase || rowHit[i / ROWSZ] ||
            (stb.arrByteErase && opAddr == ADDR_W'(i)))
          mem[i] <= ERASED;
        else if (stb.arrProg && opAddr == ADDR_W'(i))
          mem[i] <= mem[i] & opData;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cfgReg <= ERASED;
    else if (stb.cfgErase) cfgReg <= ERASED;
    else if (stb.cfgProg)  cfgReg <= cfgReg & opData;
  end

  assign tgtOld  = mem[opAddr];
  assign rdData  = mem[rdAddr];
  assign cfgData = cfgReg;

  // R2
  prog_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.arrProg |=> mem[$past(opAddr)] == ($past(tgtOld) & $past(opData)));

  // R4
  byte_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.arrByteErase |=> mem[$past(opAddr)] == ERASED);

  // R5
  row_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.arrRowErase |=>
      (mem[{$past(opAddr[ADDR_W-1:ROW_W]), ROW_W'(0)}] == ERASED) &&
      (mem[{$past(opAddr[ADDR_W-1:ROW_W]), {ROW_W{1'b1}}}] == ERASED));

  // R6
  bulk_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.arrBulkErase |=> (mem[0] == ERASED) && (mem[DEPTH-1] == ERASED) &&
                         $stable(cfgReg));

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.cfgProg || stb.cfgErase) |=> $stable(cfgReg));

  // R7
  cfg_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.cfgProg |=> cfgReg == ($past(cfgReg) & $past(opData)));

endmodule

// File: rtl/fgate_array_emu.sv
module fgate_array_emu
  import fgate_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int ROW_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opStrobe,
  input  logic              opErase,
  input  logic              modeByte,
  input  logic              modeRow,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] opData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] cfgData
);

  fgate_strobe_t stb;

  fgate_ctrl u_ctrl (
    .opStrobe (opStrobe),
    .opErase  (opErase),
    .modeByte (modeByte),
    .modeRow  (modeRow),
    .cfgSel   (cfgSel),
    .stb      (stb)
  );

  fgate_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .ROW_W  (ROW_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .opAddr  (opAddr),
    .opData  (opData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .cfgData (cfgData)
  );

endmodule

// File: tb/fgate_array_emu_tb.sv
module fgate_array_emu_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       opStrobe = 1'b0, opErase = 1'b0, modeByte = 1'b0, modeRow = 1'b0, cfgSel = 1'b0;
  logic [8:0] opAddr = '0, rdAddr = '0;
  logic [7:0] opData = '0;
  logic [7:0] rdData, cfgData;

  int   nRun = 0, nFail = 0;
  string curReq = "R1";
  logic [7:0] refMem [512];
  logic [7:0] refCfg;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  fgate_array_emu u_dut (
    .clk(clk), .rst_n(rst_n), .opStrobe(opStrobe), .opErase(opErase),
    .modeByte(modeByte), .modeRow(modeRow), .cfgSel(cfgSel),
    .opAddr(opAddr), .opData(opData), .rdAddr(rdAddr),
    .rdData(rdData), .cfgData(cfgData)
  );

  // Behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) refMem[i] = 8'hFF;
      refCfg = 8'hFF;
    end else if (opStrobe) begin
      if (cfgSel) begin
        if (!opErase) refCfg = refCfg & opData;
        else if (modeByte) refCfg = 8'hFF;
      end else if (!opErase) begin
        refMem[opAddr] = refMem[opAddr] & opData;
      end else if (modeByte) begin
        refMem[opAddr] = 8'hFF;
      end else if (modeRow) begin
        for (int i = 0; i < 512; i++)
          if ((i / 16) == int'(opAddr) / 16) refMem[i] = 8'hFF;
      end else begin
        for (int i = 0; i < 512; i++) refMem[i] = 8'hFF;
      end
    end
  end

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      nRun++;
      if (rdData !== refMem[rdAddr]) begin
        nFail++;
        $display("FAIL %s: rdData[%0h] actual %h expected %h", curReq, rdAddr, rdData, refMem[rdAddr]);
      end
      nRun++;
      if (cfgData !== refCfg) begin
        nFail++;
        $display("FAIL %s: cfgData actual %h expected %h", curReq, cfgData, refCfg);
      end
    end
  end

  task automatic doOp(input logic er, input logic mb, input logic mr, input logic cs,
                      input logic [8:0] a, input logic [7:0] d);
    @(negedge clk);
    opErase = er; modeByte = mb; modeRow = mr; cfgSel = cs;
    opAddr = a; opData = d; rdAddr = a; opStrobe = 1'b1;   // R9: old value checked this cycle
    @(negedge clk);
    opStrobe = 1'b0;                                       // R9: new value checked this cycle
  endtask

  task automatic sweep();
    for (int i = 0; i < 512; i++) begin
      @(negedge clk);
      rdAddr = 9'(i);
    end
    @(negedge clk);
  endtask

  task automatic nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #1000000;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    curReq = "R1";
    sweep();

    curReq = "R2";
    for (int k = 0; k < 40; k++) begin
      nextRand();
      doOp(1'b0, 1'b0, 1'b0, 1'b0, lfsr[8:0], lfsr[15:8]);
    end
    doOp(1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 8'hF0);
    doOp(1'b0, 1'b0, 1'b0, 1'b0, 9'h1FF, 8'h5A);
    sweep();

    curReq = "R3";
    doOp(1'b0, 1'b0, 1'b0, 1'b0, 9'h042, 8'h0F);
    doOp(1'b0, 1'b0, 1'b0, 1'b0, 9'h042, 8'hFF);
    doOp(1'b0, 1'b0, 1'b0, 1'b0, 9'h042, 8'hF3);
    doOp(1'b0, 1'b0, 1'b0, 1'b0, 9'h042, 8'hFF);

    curReq = "R5";
    for (int i = 0; i < 512; i += 5) doOp(1'b0, 1'b0, 1'b0, 1'b0, 9'(i), 8'h00);
    doOp(1'b1, 1'b0, 1'b1, 1'b0, 9'h035, 8'h00);
    doOp(1'b1, 1'b0, 1'b1, 1'b0, 9'h1F7, 8'h00);
    sweep();

    curReq = "R4";
    doOp(1'b1, 1'b1, 1'b0, 1'b0, 9'h000, 8'h00);
    doOp(1'b1, 1'b1, 1'b1, 1'b0, 9'h005, 8'h00);
    doOp(1'b1, 1'b1, 1'b1, 1'b0, 9'h10E, 8'h00);
    sweep();

    curReq = "R7";
    doOp(1'b0, 1'b0, 1'b0, 1'b1, 9'h00A, 8'hC3);
    doOp(1'b0, 1'b0, 1'b0, 1'b1, 9'h00A, 8'h7E);
    sweep();

    curReq = "R8";
    doOp(1'b1, 1'b0, 1'b1, 1'b1, 9'h00A, 8'h00);
    doOp(1'b1, 1'b0, 1'b0, 1'b1, 9'h00A, 8'h00);
    sweep();

    curReq = "R6";
    doOp(1'b1, 1'b0, 1'b0, 1'b0, 9'h123, 8'h00);
    sweep();

    curReq = "R7";
    doOp(1'b1, 1'b1, 1'b0, 1'b1, 9'h000, 8'h00);

    curReq = "R10";
    doOp(1'b0, 1'b0, 1'b0, 1'b0, 9'h077, 8'h11);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      nextRand();
      opErase = lfsr[0]; modeByte = lfsr[1]; modeRow = lfsr[2]; cfgSel = lfsr[3];
      opAddr = lfsr[12:4]; opData = lfsr[15:8]; rdAddr = 9'h077;
    end
    sweep();

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule